// File: doc/BRIEF.md
# Drum speed and phase lock controller

This block drives the power word of a head-drum motor in two stages. After reset it runs a speed loop. It timestamps each rising edge of the drum sensor against a free-running microsecond counter. It measures the time between successive drum edges and nudges the power word up or down by a coarse step whenever that period lies outside a configured window. In-window periods are counted, and once enough have been seen the block switches to a phase loop.

In the phase loop, every drum edge is compared with the most recent video sync edge. The drum-minus-video time is held inside a phase window by corrections of a fine step. Each measurement, in either loop, produces a one-cycle strobe that hands the new power word to a downstream PWM generator. A stop request is looked at only when a tracking measurement completes. Once it is honoured, the block goes quiet until the next reset.

Both sync inputs are asynchronous. They pass through a two-flop synchroniser and a rising-edge detector before they are timestamped. All windows, steps and the qualification count are run-time inputs.

Top module: `drum_phase_lock`

## Requirements
- R1: After reset, power_o is 0, power_valid_o is 0 and mode_o is 2'b00 (speed loop). The mode encodings are 2'b00 speed loop, 2'b01 phase loop and 2'b10 stopped.
- R2: The first drum rising edge after reset only records a reference timestamp. It produces no strobe and leaves power_o unchanged.
- R3: In the speed loop, a drum period greater than period_max_i raises power_o by coarse_step_i. The new value is presented with a one-cycle power_valid_o strobe.
- R4: In the speed loop, a drum period less than period_min_i lowers power_o by coarse_step_i, again with a strobe.
- R5: Power arithmetic saturates at 0 and at all-ones of the power width instead of wrapping.
- R6: A period within [period_min_i, period_max_i] (inclusive) leaves power_o unchanged, still strobes, and increments a qualification count. Out-of-window periods do not clear that count. The measurement that takes the count above good_limit_i moves mode_o to 2'b01, and the block never returns to the speed loop.
- R7: Periods and phase differences are computed as modulo differences of the microsecond timestamp width, so they remain correct across counter wrap.
- R8: In the phase loop, each drum edge measures drum time minus last video time. A value below phase_min_i raises power_o by fine_step_i. A value above phase_max_i lowers it by fine_step_i. A value inside the window leaves power_o unchanged. Every such measurement strobes.
- R9: When drum and video edges are detected in the same cycle during the phase loop, the new video timestamp is used, so the measured difference is 0.
- R10: stop_i has effect only at a phase-loop measurement. If it is high then, the measurement still completes with a strobe and mode_o becomes 2'b10. After that, drum edges produce no strobe and no change to power_o.
- R11: Each input pulse yields exactly one measurement, however long the input stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| drum_sync_i | input | 1 | Drum sensor pulse, asynchronous |
| video_sync_i | input | 1 | Video frame sync pulse, asynchronous |
| stop_i | input | 1 | Request to leave the phase loop |
| period_min_i | input | TS_W | Lower bound of the accepted drum period, µs |
| period_max_i | input | TS_W | Upper bound of the accepted drum period, µs |
| phase_min_i | input | TS_W | Lower bound of the drum-to-video offset, µs |
| phase_max_i | input | TS_W | Upper bound of the drum-to-video offset, µs |
| coarse_step_i | input | PWR_W | Speed-loop correction step |
| fine_step_i | input | PWR_W | Phase-loop correction step |
| good_limit_i | input | GOOD_W | In-window count that must be exceeded to switch loops |
| power_o | output | PWR_W | Motor power word |
| power_valid_o | output | 1 | One-cycle strobe for a new power word |
| mode_o | output | 2 | Current loop: 00 speed, 01 phase, 10 stopped |

## Verification
In the phase loop, a video timestamp capture and a drum measurement can land in the same clock cycle. The measurement must then use the freshly captured video time rather than the stored one. The bench provokes this by raising both sync inputs on the same clock. It judges the result by the correction: with a zero difference below phase_min_i, power_o must rise by exactly one fine step. The bench also holds stop_i high across a video-only pulse, where it must have no effect. It then keeps stop_i high into a drum measurement, where the update and the move to the stopped mode must both occur.

// File: rtl/drum_lock_pkg.sv
package drum_lock_pkg;
  typedef enum logic [1:0] {
    MODE_ACCEL = 2'b00,
    MODE_TRACK = 2'b01,
    MODE_IDLE  = 2'b10
  } lock_mode_e;
endpackage

// File: rtl/sync_rise_det.sv
module sync_rise_det #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q[0] <= 1'b0;
    else         pipe_q[0] <= async_i;
  end

  for (genvar i = 1; i <= STAGES; i++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pipe_q[i] <= 1'b0;
      else         pipe_q[i] <= pipe_q[i-1];
    end
  end

  assign rise_o = pipe_q[STAGES-1] & ~pipe_q[STAGES];

  assert_single_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/usec_timebase.sv
module usec_timebase #(
  parameter int CLK_PER_US = 250,
  parameter int TS_W       = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  output logic [TS_W-1:0] usec_o
);
  localparam int PS_W = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
  localparam logic [PS_W-1:0] PS_LAST = PS_W'(CLK_PER_US - 1);

  logic [PS_W-1:0] ps_q;
  logic [TS_W-1:0] usec_q;
  logic            tick;

  assign tick = (ps_q == PS_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ps_q   <= '0;
      usec_q <= '0;
    end else begin
      ps_q <= tick ? '0 : ps_q + 1'b1;
      if (tick) usec_q <= usec_q + 1'b1;
    end
  end

  assign usec_o = usec_q;

  assert_count_on_tick_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick |=> $stable(usec_q));
endmodule

// File: rtl/sat_step.sv
module sat_step #(
  parameter int W = 12
) (
  input  logic [W-1:0] val_i,
  input  logic [W-1:0] step_i,
  input  logic         up_i,
  input  logic         down_i,
  output logic [W-1:0] val_o
);
  logic [W:0] sum;
  assign sum = {1'b0, val_i} + {1'b0, step_i};

  always_comb begin
    if (up_i)        val_o = sum[W] ? '1 : sum[W-1:0];
    else if (down_i) val_o = (step_i > val_i) ? '0 : val_i - step_i;
    else             val_o = val_i;
  end
endmodule

// File: rtl/drum_lock_ctrl.sv
module drum_lock_ctrl
  import drum_lock_pkg::*;
#(
  parameter int TS_W   = 16,
  parameter int PWR_W  = 12,
  parameter int GOOD_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              drum_edge_i,
  input  logic              video_edge_i,
  input  logic [TS_W-1:0]   now_i,
  input  logic              stop_i,
  input  logic [TS_W-1:0]   period_min_i,
  input  logic [TS_W-1:0]   period_max_i,
  input  logic [TS_W-1:0]   phase_min_i,
  input  logic [TS_W-1:0]   phase_max_i,
  input  logic [PWR_W-1:0]  coarse_step_i,
  input  logic [PWR_W-1:0]  fine_step_i,
  input  logic [GOOD_W-1:0] good_limit_i,
  output logic [PWR_W-1:0]  power_o,
  output logic              power_valid_o,
  output lock_mode_e        mode_o
);
  lock_mode_e        mode_q;
  logic              have_ref_q;
  logic [TS_W-1:0]   ref_ts_q, vid_ts_q;
  logic [GOOD_W-1:0] good_q;
  logic [PWR_W-1:0]  power_q, power_nxt, step;
  logic              valid_q;

  logic [TS_W-1:0]   period, phase, vid_eff;
  logic [GOOD_W:0]   good_inc;
  logic              in_accel, in_track, meas, up, down, in_win, qualify;

  assign in_accel = (mode_q == MODE_ACCEL);
  assign in_track = (mode_q == MODE_TRACK);

  // modulo differences tolerate timestamp wrap
  assign period  = now_i - ref_ts_q;
  assign vid_eff = video_edge_i ? now_i : vid_ts_q;
  assign phase   = now_i - vid_eff;

  assign meas = drum_edge_i && ((in_accel && have_ref_q) || in_track);

  always_comb begin
    up   = 1'b0;
    down = 1'b0;
    if (meas && in_accel) begin
      up   = period > period_max_i;
      down = period < period_min_i;
    end else if (meas && in_track) begin
      up   = phase < phase_min_i;
      down = phase > phase_max_i;
    end
  end

  assign step     = in_accel ? coarse_step_i : fine_step_i;
  assign in_win   = !(period > period_max_i) && !(period < period_min_i);
  assign good_inc = {1'b0, good_q} + 1'b1;
  assign qualify  = meas && in_accel && in_win;

  sat_step #(.W(PWR_W)) i_sat_step (
    .val_i  (power_q),
    .step_i (step),
    .up_i   (up),
    .down_i (down),
    .val_o  (power_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q     <= MODE_ACCEL;
      have_ref_q <= 1'b0;
      ref_ts_q   <= '0;
      vid_ts_q   <= '0;
      good_q     <= '0;
      power_q    <= '0;
      valid_q    <= 1'b0;
    end else begin
      valid_q <= meas;
      if (video_edge_i) vid_ts_q <= now_i;
      if (drum_edge_i && in_accel) begin
        ref_ts_q   <= now_i;
        have_ref_q <= 1'b1;
      end
      if (meas) power_q <= power_nxt;
      if (qualify) begin
        good_q <= good_inc[GOOD_W-1:0];
        if (good_inc > {1'b0, good_limit_i}) mode_q <= MODE_TRACK;
      end
      if (meas && in_track && stop_i) mode_q <= MODE_IDLE;
    end
  end

  assign power_o       = power_q;
  assign power_valid_o = valid_q;
  assign mode_o        = mode_q;

  assert_power_moves_with_strobe_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_q |-> $stable(power_q));
  assert_no_return_to_speed_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q != MODE_ACCEL) |=> (mode_q != MODE_ACCEL));
  assert_idle_silent_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_IDLE) |=> !valid_q);
endmodule

// File: rtl/drum_phase_lock.sv
module drum_phase_lock
  import drum_lock_pkg::*;
#(
  parameter int CLK_PER_US  = 250,
  parameter int TS_W        = 16,
  parameter int PWR_W       = 12,
  parameter int GOOD_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              drum_sync_i,
  input  logic              video_sync_i,
  input  logic              stop_i,
  input  logic [TS_W-1:0]   period_min_i,
  input  logic [TS_W-1:0]   period_max_i,
  input  logic [TS_W-1:0]   phase_min_i,
  input  logic [TS_W-1:0]   phase_max_i,
  input  logic [PWR_W-1:0]  coarse_step_i,
  input  logic [PWR_W-1:0]  fine_step_i,
  input  logic [GOOD_W-1:0] good_limit_i,
  output logic [PWR_W-1:0]  power_o,
  output logic              power_valid_o,
  output logic [1:0]        mode_o
);
  logic            drum_edge, video_edge;
  logic [TS_W-1:0] now_us;
  lock_mode_e      mode;

  sync_rise_det #(.STAGES(SYNC_STAGES)) i_drum_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .async_i(drum_sync_i), .rise_o(drum_edge));

  sync_rise_det #(.STAGES(SYNC_STAGES)) i_video_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .async_i(video_sync_i), .rise_o(video_edge));

  usec_timebase #(.CLK_PER_US(CLK_PER_US), .TS_W(TS_W)) i_timebase (
    .clk_i(clk_i), .rst_ni(rst_ni), .usec_o(now_us));

  drum_lock_ctrl #(.TS_W(TS_W), .PWR_W(PWR_W), .GOOD_W(GOOD_W)) i_ctrl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .drum_edge_i   (drum_edge),
    .video_edge_i  (video_edge),
    .now_i         (now_us),
    .stop_i        (stop_i),
    .period_min_i  (period_min_i),
    .period_max_i  (period_max_i),
    .phase_min_i   (phase_min_i),
    .phase_max_i   (phase_max_i),
    .coarse_step_i (coarse_step_i),
    .fine_step_i   (fine_step_i),
    .good_limit_i  (good_limit_i),
    .power_o       (power_o),
    .power_valid_o (power_valid_o),
    .mode_o        (mode)
  );

  assign mode_o = mode;

  assert_strobe_from_edge_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    power_valid_o |-> $past(drum_edge));
endmodule

// File: tb/test_drum_phase_lock.sv
`timescale 1ns/1ps
module test_drum_phase_lock;
  localparam int CPU    = 2;
  localparam int TS_W   = 8;
  localparam int PWR_W  = 8;
  localparam int GOOD_W = 4;
  localparam int FIRE   = 8;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              drum_sync_i = 1'b0, video_sync_i = 1'b0, stop_i = 1'b0;
  logic [TS_W-1:0]   period_min_i = 8'd90, period_max_i = 8'd110;
  logic [TS_W-1:0]   phase_min_i = 8'd20, phase_max_i = 8'd30;
  logic [PWR_W-1:0]  coarse_step_i = 8'd100, fine_step_i = 8'd5;
  logic [GOOD_W-1:0] good_limit_i = 4'd2;
  logic [PWR_W-1:0]  power_o;
  logic              power_valid_o;
  logic [1:0]        mode_o;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  drum_phase_lock #(.CLK_PER_US(CPU), .TS_W(TS_W), .PWR_W(PWR_W), .GOOD_W(GOOD_W))
    i_drum_phase_lock (.*);

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  // raise chosen inputs for 4 cycles, count strobes over FIRE cycles
  task automatic fire(bit d, bit v, output int n);
    n = 0;
    drum_sync_i  = d;
    video_sync_i = v;
    for (int i = 0; i < FIRE; i++) begin
      @(negedge clk_i);
      if (power_valid_o) n++;
      if (i == 3) begin
        drum_sync_i  = 1'b0;
        video_sync_i = 1'b0;
      end
    end
  endtask

  task automatic gap_fire(int us, bit d, bit v, output int n);
    repeat (us * CPU - FIRE) @(negedge clk_i);
    fire(d, v, n);
  endtask

  task automatic speed_step(int us, int exp_pwr, int exp_mode, string req);
    int n;
    gap_fire(us, 1'b1, 1'b0, n);
    check({req, " strobe count (R11)"}, n, 1);
    check({req, " power"}, power_o, exp_pwr);
    check({req, " mode"}, mode_o, exp_mode);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 power", power_o, 0);
    check("R1 strobe", power_valid_o, 0);
    check("R1 mode", mode_o, 0);
  endtask

  task automatic t_reference;
    int n;
    fire(1'b1, 1'b0, n);
    check("R2 no strobe on first edge", n, 0);
    check("R2 power unchanged", power_o, 0);
  endtask

  task automatic t_speed_coarse;
    speed_step(200, 100, 0, "R3 slow");
    speed_step(200, 200, 0, "R3 R7 slow across wrap");
    speed_step(200, 255, 0, "R5 top saturation");
    speed_step(50, 155, 0, "R4 fast");
    speed_step(50, 55, 0, "R4 fast");
    speed_step(50, 0, 0, "R5 floor saturation");
  endtask

  task automatic t_qualify;
    speed_step(100, 0, 0, "R6 in window 1");
    speed_step(90, 0, 0, "R6 in window 2 lower bound");
    speed_step(200, 100, 0, "R6 out of window keeps count");
    speed_step(110, 100, 1, "R6 third in window switches");
  endtask

  task automatic track_meas(int d_us, int exp_pwr, string req);
    int n;
    gap_fire(30, 1'b0, 1'b1, n);
    check({req, " video only no strobe"}, n, 0);
    gap_fire(d_us, 1'b1, 1'b0, n);
    check({req, " strobe"}, n, 1);
    check({req, " power"}, power_o, exp_pwr);
    check({req, " mode"}, mode_o, 1);
  endtask

  task automatic t_track;
    track_meas(10, 105, "R8 behind");
    track_meas(40, 100, "R8 ahead");
    track_meas(25, 100, "R8 in window");
  endtask

  task automatic t_coincide;
    int n;
    gap_fire(30, 1'b1, 1'b1, n);
    check("R9 strobe", n, 1);
    check("R9 power uses zero difference", power_o, 105);
  endtask

  task automatic t_stop;
    int n;
    stop_i = 1'b1;
    gap_fire(30, 1'b0, 1'b1, n);
    check("R10 stop ignored without measurement", mode_o, 1);
    gap_fire(25, 1'b1, 1'b0, n);
    check("R10 final strobe", n, 1);
    check("R10 mode stopped", mode_o, 2);
    check("R10 power", power_o, 105);
    gap_fire(30, 1'b1, 1'b0, n);
    check("R10 no strobe when stopped", n, 0);
    check("R10 power held when stopped", power_o, 105);
    stop_i = 1'b0;
  endtask

  initial begin
    t_reset();
    t_reference();
    t_speed_coarse();
    t_qualify();
    t_track();
    t_coincide();
    t_stop();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule